// File: doc/BRIEF.md
# Message Interrupt Enable Gate

This block holds the host-writable interrupt enable register of a bus remote terminal and turns message-processing events into a message interrupt pulse. Two event kinds are handled. The first is index-reaches-zero, raised when an indexed buffer's index steps from 1 to 0 or when a circular buffer completes its preset message count. The second is accessed, raised for each message to a subaddress whose descriptor allows it.

An event raises the interrupt only when two enables are set: the global enable bit for its kind in this register and the per-command flag carried alongside the event from the descriptor control word. Events are never stored. Setting an enable after its event has happened produces no interrupt for that event. The register is cleared only by master reset. Software reset has no effect on it.

Top module: `msg_irq_gate`

## Requirements
- R1: While master reset `mst_rst` is high, and in the cycle after it is released, `rd_data` reads 0 and `msg_irq` is 0.
- R2: A write (`wr_en` high at a clock edge) stores `wr_data`. From the next cycle `rd_data` returns the written value with bits 2..0 forced to 0. Bit 15 is the index-zero enable and bit 14 is the accessed enable. Bits 13..3 are plain storage.
- R3: Software reset `sw_rst` never changes the stored register value.
- R4: When `ixz_evt` and `ixz_ctl` are both high at an edge and bit 15 is set, `msg_irq` is high for exactly the following cycle.
- R5: When `iwa_evt` and `iwa_ctl` are both high at an edge and bit 14 is set, `msg_irq` is high for exactly the following cycle.
- R6: An event produces no pulse when either its global bit or its descriptor flag is 0.
- R7: Events are not remembered. An enable written in the same cycle as an event, or any later cycle, gives no pulse for that event.
- R8: If both event kinds qualify at the same edge, `msg_irq` is a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mst_rst | input | 1 | Master reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, active high; does not touch this register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data, low three bits always 0 |
| ixz_evt | input | 1 | Index-reaches-zero event pulse |
| ixz_ctl | input | 1 | Descriptor flag allowing index-zero interrupt |
| iwa_evt | input | 1 | Accessed event pulse |
| iwa_ctl | input | 1 | Descriptor flag allowing accessed interrupt |
| msg_irq | output | 1 | Message interrupt, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit register, three read-only low bits, and the two enables at bits 15 and 14. With these values, writes of all-ones and of alternating patterns show exactly which bits store and which read 0. Every combination of global bit, descriptor flag and event can be driven for both kinds. The bench also covers an enable write that lands in the same edge as an event, and two events that qualify together.

// File: rtl/msg_irq_gate.sv
module msg_irq_gate #(
  parameter int WIDTH   = 16,
  parameter int RO_LSBS = 3,
  parameter int IXZ_POS = 15,
  parameter int IWA_POS = 14
) (
  input  logic             clk,
  input  logic             mst_rst,
  input  logic             sw_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             ixz_evt,
  input  logic             ixz_ctl,
  input  logic             iwa_evt,
  input  logic             iwa_ctl,
  output logic             msg_irq
);
  localparam logic [WIDTH-1:0] WMASK = {{(WIDTH-RO_LSBS){1'b1}}, {RO_LSBS{1'b0}}};

  logic [WIDTH-1:0] en_q;
  logic             ixz_hit, iwa_hit, irq_q;

  // sw_rst deliberately has no path into this register
  always_ff @(posedge clk) begin
    if (mst_rst)    en_q <= '0;
    else if (wr_en) en_q <= wr_data & WMASK;
  end

  assign ixz_hit = ixz_evt & ixz_ctl & en_q[IXZ_POS];
  assign iwa_hit = iwa_evt & iwa_ctl & en_q[IWA_POS];

  always_ff @(posedge clk) begin
    if (mst_rst) irq_q <= 1'b0;
    else         irq_q <= ixz_hit | iwa_hit;
  end

  assign rd_data = en_q & WMASK;
  assign msg_irq = irq_q;
endmodule

module msg_irq_gate_chk #(
  parameter int WIDTH   = 16,
  parameter int RO_LSBS = 3,
  parameter int IXZ_POS = 15,
  parameter int IWA_POS = 14
) (
  input logic             clk,
  input logic             mst_rst,
  input logic             sw_rst,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic             ixz_evt,
  input logic             ixz_ctl,
  input logic             iwa_evt,
  input logic             iwa_ctl,
  input logic             msg_irq
);
  localparam logic [WIDTH-1:0] WMASK = {{(WIDTH-RO_LSBS){1'b1}}, {RO_LSBS{1'b0}}};

  // R1
  rst_clear_chk: assert property (@(posedge clk) mst_rst |=> (rd_data == '0 && !msg_irq));
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (mst_rst)
    wr_en |=> rd_data == ($past(wr_data) & WMASK));
  // R3
  sw_keep_chk: assert property (@(posedge clk) disable iff (mst_rst)
    (sw_rst && !wr_en) |=> $stable(rd_data));
  // R4
  ixz_fire_chk: assert property (@(posedge clk) disable iff (mst_rst)
    (ixz_evt && ixz_ctl && rd_data[IXZ_POS]) |=> msg_irq);
  // R5
  iwa_fire_chk: assert property (@(posedge clk) disable iff (mst_rst)
    (iwa_evt && iwa_ctl && rd_data[IWA_POS]) |=> msg_irq);
  // R6
  no_cause_chk: assert property (@(posedge clk) disable iff (mst_rst)
    !((ixz_evt && ixz_ctl && rd_data[IXZ_POS]) || (iwa_evt && iwa_ctl && rd_data[IWA_POS]))
    |=> !msg_irq);
endmodule

bind msg_irq_gate msg_irq_gate_chk #(
  .WIDTH(WIDTH), .RO_LSBS(RO_LSBS), .IXZ_POS(IXZ_POS), .IWA_POS(IWA_POS)
) u_chk (.*);

// File: tb/msg_irq_gate_tb.sv
module msg_irq_gate_tb;
  logic        clk = 1'b0;
  logic        mst_rst = 1'b1, sw_rst = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ixz_evt = 1'b0, ixz_ctl = 1'b0, iwa_evt = 1'b0, iwa_ctl = 1'b0;
  logic        msg_irq;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  msg_irq_gate u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(input bit ie, input bit ic, input bit ae, input bit ac, input bit exp, input string req);
    ixz_evt = ie; ixz_ctl = ic; iwa_evt = ae; iwa_ctl = ac;
    @(negedge clk);
    ixz_evt = 0; ixz_ctl = 0; iwa_evt = 0; iwa_ctl = 0;
    check(msg_irq == exp, req, msg_irq, exp);
    @(negedge clk);
    check(msg_irq == 1'b0, {req, " width"}, msg_irq, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(rd_data == 16'h0 && !msg_irq, "R1 in reset", rd_data, 0);
    mst_rst = 1'b0;
    @(negedge clk);
    check(rd_data == 16'h0 && !msg_irq, "R1 after release", rd_data, 0);
  endtask

  task automatic t_rw;
    wr(16'hFFFF);
    check(rd_data == 16'hFFF8, "R2 all ones", rd_data, 16'hFFF8);
    wr(16'h5555);
    check(rd_data == 16'h5550, "R2 pattern 5", rd_data, 16'h5550);
    wr(16'hAAAA);
    check(rd_data == 16'hAAA8, "R2 pattern A", rd_data, 16'hAAA8);
    wr(16'h0007);
    check(rd_data == 16'h0000, "R2 ro bits", rd_data, 0);
  endtask

  task automatic t_swrst;
    wr(16'hC0F8);
    sw_rst = 1'b1;
    @(negedge clk); @(negedge clk);
    sw_rst = 1'b0;
    check(rd_data == 16'hC0F8, "R3 sw reset keeps", rd_data, 16'hC0F8);
    mst_rst = 1'b1;
    @(negedge clk);
    mst_rst = 1'b0;
    check(rd_data == 16'h0, "R1 master clears", rd_data, 0);
  endtask

  task automatic t_ixz;
    wr(16'h8000);
    fire(1, 1, 0, 0, 1, "R4 ixz pulse");
  endtask

  task automatic t_iwa;
    wr(16'h4000);
    fire(0, 0, 1, 1, 1, "R5 iwa pulse");
  endtask

  task automatic t_gating;
    wr(16'h4000);
    fire(1, 1, 0, 0, 0, "R6 ixz global off");
    wr(16'h8000);
    fire(1, 0, 0, 0, 0, "R6 ixz ctl off");
    fire(0, 0, 1, 1, 0, "R6 iwa global off");
    wr(16'h4000);
    fire(0, 0, 1, 0, 0, "R6 iwa ctl off");
    wr(16'h3FF8);
    fire(1, 1, 1, 1, 0, "R6 other bits");
  endtask

  task automatic t_late;
    wr(16'h0000);
    ixz_evt = 1; ixz_ctl = 1; iwa_evt = 1; iwa_ctl = 1;
    wr_en = 1'b1; wr_data = 16'hC000;
    @(negedge clk);
    wr_en = 1'b0; ixz_evt = 0; ixz_ctl = 0; iwa_evt = 0; iwa_ctl = 0;
    check(!msg_irq, "R7 same-cycle enable", msg_irq, 0);
    @(negedge clk);
    check(!msg_irq, "R7 no later pulse", msg_irq, 0);
    @(negedge clk);
    check(!msg_irq, "R7 still none", msg_irq, 0);
  endtask

  task automatic t_both;
    wr(16'hC000);
    fire(1, 1, 1, 1, 1, "R8 both qualify");
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rw();
    t_swrst();
    t_ixz();
    t_iwa();
    t_gating();
    t_late();
    t_both();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule